// File: doc/BRIEF.md
# Tile Region Grower

This block finds the connected foreground regions in one 20x20 tile of a binary object map and reports a bounding box for each. After a start pulse it copies the tile into an internal snapshot through a zero-latency read port. It then walks the tile in raster order looking for a foreground element that no region has claimed yet. Each such seed starts a wavefront expansion. A frontier memory holds the coordinates still waiting to be expanded. When the frontier runs dry, the region's box is emitted with the tile's origin added, and the raster walk resumes.

Expansion runs in one of two modes, chosen per element. If the element's right, lower and lower-right neighbours are all foreground, it is expanded as a 2x2 block. The three partners are claimed at once and the eight cells bordering the block are examined in one step. Otherwise it is expanded alone, examining its four horizontal and vertical neighbours. Newly found cells are claimed at once and pushed to the frontier one per cycle.

The controller has the states IDLE, LOAD, SCAN, POP, PUSH, EMIT and FINISH, with these transitions:
- IDLE to LOAD on start.
- LOAD to SCAN after the last address.
- SCAN to POP on a seed.
- SCAN to FINISH at the end of the tile.
- POP to PUSH when candidates were found.
- POP to POP when none were found.
- POP to EMIT when the frontier is empty.
- PUSH to POP when the last candidate is written.
- EMIT to SCAN.
- FINISH to IDLE.

Top module: `tile_region_grower`

## Requirements
- R1: After reset, region_valid and done are low and tile_rd_addr is 0.
- R2: A start seen in IDLE makes the block read tile addresses 0 to 399, one per cycle, in the consecutive cycles that follow. The address of element (x,y) is y*20+x, and tile_rd_data must reflect tile_rd_addr in the same cycle.
- R3: Each 4-connected group of foreground elements produces exactly one region_valid pulse. Its inclusive minimum and maximum x and y bounds are exact.
- R4: Regions are reported in ascending order of the lowest raster address among their elements.
- R5: Reported bounds equal the tile coordinates plus org_x/org_y as sampled in the cycle start was accepted.
- R6: done is high for exactly one cycle, after the last region and never together with region_valid. A tile with no foreground gives done and no region.
- R7: start while the block is not in IDLE is ignored. The results, the origin used and the single done pulse are unchanged.
- R8: An element whose right, lower and lower-right neighbours are foreground is expanded as a 2x2 block, examining its eight bordering cells in one step. Results stay identical to plain 4-connectivity for solid, concave and edge-touching shapes.
- R9: Elements touching only diagonally are separate regions, and nothing wraps across tile edges.
- R10: The frontier word holds x in bits 4:0, y in bits 9:5, and in bit 10 a flag set when a block step pushed it; bits 12:11 are zero. The frontier never overflows or underflows, even for a full tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| start | input | 1 | Begin processing a tile (accepted in IDLE only) |
| org_x | input | 7 | Tile x origin in map coordinates |
| org_y | input | 7 | Tile y origin in map coordinates |
| tile_rd_addr | output | 9 | Tile memory read address, y*20+x |
| tile_rd_data | input | 1 | Foreground bit at tile_rd_addr, same cycle |
| region_valid | output | 1 | One-cycle pulse: region bounds are valid |
| region_min_x | output | 7 | Leftmost column of the region plus origin |
| region_max_x | output | 7 | Rightmost column of the region plus origin |
| region_min_y | output | 7 | Top row of the region plus origin |
| region_max_y | output | 7 | Bottom row of the region plus origin |
| done | output | 1 | One-cycle pulse: tile finished |

## Verification
The bench runs the following tiles and compares every emitted box, in order, against a flood fill computed in the bench:
- an empty tile;
- a full tile;
- single pixels at the first and last addresses;
- a diagonal pair;
- a checkerboard;
- concave shapes built from 2x2 blocks along the right and bottom edges;
- random fills at several densities.

A grower that treated diagonal contact as a connection would merge checkerboard cells into one region. A block expansion that skipped the bordering cells of its partners would split U-shapes or shrink their boxes. Letting the block mode run past the last column would leak regions across the edge. A second start pulse is driven during loading and during scanning. A design that honoured it would restart with a shifted origin and repeat or misplace the boxes.

// File: rtl/rg_pkg.sv
package rg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SCAN,
        ST_POP,
        ST_PUSH,
        ST_EMIT,
        ST_FINISH
    } rg_state_t;

    // Candidate slots per expansion step: 4 used in single mode, 8 in block mode
    localparam int NSLOT = 8;

    function automatic int slot_dx(input logic blk, input int s);
        if (!blk) begin
            case (s)
                0:       return -1;
                1:       return 1;
                default: return 0;
            endcase
        end else begin
            case (s)
                0, 4:    return -1;
                1, 5:    return 2;
                6, 7:    return 1;
                default: return 0;
            endcase
        end
    endfunction

    function automatic int slot_dy(input logic blk, input int s);
        if (!blk) begin
            case (s)
                2:       return -1;
                3:       return 1;
                default: return 0;
            endcase
        end else begin
            case (s)
                2, 6:    return -1;
                3, 7:    return 2;
                4, 5:    return 1;
                default: return 0;
            endcase
        end
    endfunction

endpackage

// File: rtl/rg_frontier_fifo.sv
module rg_frontier_fifo #(
    parameter int DEPTH = 400,
    parameter int WW    = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [WW-1:0] wdata,
    input  logic          pop,
    output logic [WW-1:0] rdata,
    output logic          empty,
    output logic          full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CNW = $clog2(DEPTH + 1);

    logic [WW-1:0]  mem [DEPTH];
    logic [PW-1:0]  wp, rp;
    logic [CNW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clear) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            cnt <= cnt + CNW'(push) - CNW'(pop);
        end
    end

    assign rdata = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CNW'(DEPTH));

    // R10: frontier bounds
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |-> !full);
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/rg_neighbour_gen.sv
module rg_neighbour_gen
    import rg_pkg::*;
#(
    parameter int TW = 20,
    parameter int TH = 20,
    parameter int CW = 5,
    parameter int AW = 9
) (
    input  logic [CW-1:0]                cx,
    input  logic [CW-1:0]                cy,
    input  logic [TW*TH-1:0]             fg,
    output logic                         blk,
    output logic [NSLOT-1:0]             cand_ok,
    output logic [NSLOT-1:0][CW-1:0]     nx,
    output logic [NSLOT-1:0][CW-1:0]     ny,
    output logic [NSLOT-1:0][AW-1:0]     na
);
    always_comb begin
        int xi, yi, tx, ty;
        xi  = int'(cx);
        yi  = int'(cy);
        blk = 1'b0;
        if ((xi + 1 < TW) && (yi + 1 < TH))
            blk = fg[AW'(yi * TW + xi + 1)] & fg[AW'((yi + 1) * TW + xi)]
                & fg[AW'((yi + 1) * TW + xi + 1)];
        for (int s = 0; s < NSLOT; s++) begin
            tx = xi + slot_dx(blk, s);
            ty = yi + slot_dy(blk, s);
            cand_ok[s] = (blk || s < 4) && tx >= 0 && tx < TW && ty >= 0 && ty < TH;
            nx[s] = CW'(tx);
            ny[s] = CW'(ty);
            na[s] = cand_ok[s] ? AW'(ty * TW + tx) : '0;
        end
    end

endmodule

// File: rtl/rg_bbox.sv
module rg_bbox #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic [CW-1:0] ix,
    input  logic [CW-1:0] iy,
    input  logic          upd,
    input  logic [CW-1:0] ux,
    input  logic [CW-1:0] uy,
    output logic [CW-1:0] min_x,
    output logic [CW-1:0] max_x,
    output logic [CW-1:0] min_y,
    output logic [CW-1:0] max_y
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_x <= '0;
            max_x <= '0;
            min_y <= '0;
            max_y <= '0;
        end else if (init) begin
            min_x <= ix;
            max_x <= ix;
            min_y <= iy;
            max_y <= iy;
        end else if (upd) begin
            if (ux < min_x) min_x <= ux;
            if (ux > max_x) max_x <= ux;
            if (uy < min_y) min_y <= uy;
            if (uy > max_y) max_y <= uy;
        end
    end

endmodule

// File: rtl/tile_region_grower.sv
module tile_region_grower
    import rg_pkg::*;
#(
    parameter int TILE_W = 20,
    parameter int TILE_H = 20,
    parameter int ORG_W  = 7
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic [ORG_W-1:0]                    org_x,
    input  logic [ORG_W-1:0]                    org_y,
    output logic [$clog2(TILE_W*TILE_H)-1:0]    tile_rd_addr,
    input  logic                                tile_rd_data,
    output logic                                region_valid,
    output logic [ORG_W-1:0]                    region_min_x,
    output logic [ORG_W-1:0]                    region_max_x,
    output logic [ORG_W-1:0]                    region_min_y,
    output logic [ORG_W-1:0]                    region_max_y,
    output logic                                done
);
    localparam int NPT    = TILE_W * TILE_H;
    localparam int AW     = $clog2(NPT);
    localparam int CW     = $clog2((TILE_W > TILE_H) ? TILE_W : TILE_H);
    localparam int WORD_W = 2 * CW + 3;
    localparam int SW     = $clog2(NSLOT);

    rg_state_t state, nstate;

    logic [NPT-1:0]          fg, vis;
    logic [AW-1:0]           cnt;
    logic [CW-1:0]           cx, cy;
    logic [ORG_W-1:0]        ox_q, oy_q;
    logic [NSLOT-1:0]        cand_q;
    logic [NSLOT-1:0][CW-1:0] cand_x_q, cand_y_q;
    logic                    mode_q;

    // frontier
    logic                    f_push, f_pop, f_empty, f_full, f_clear;
    logic [WORD_W-1:0]       f_wdata, f_rdata;
    logic [CW-1:0]           hx, hy;
    logic [AW-1:0]           head_a;
    logic                    mode_unused;

    assign hx          = f_rdata[CW-1:0];
    assign hy          = f_rdata[2*CW-1:CW];
    assign mode_unused = f_rdata[2*CW];
    assign head_a      = AW'(int'(hy) * TILE_W + int'(hx));

    // neighbour generation for the head element
    logic                      blk;
    logic [NSLOT-1:0]          cand_ok, new_mask;
    logic [NSLOT-1:0][CW-1:0]  nx, ny;
    logic [NSLOT-1:0][AW-1:0]  na;

    rg_neighbour_gen #(.TW(TILE_W), .TH(TILE_H), .CW(CW), .AW(AW)) u_nbr (
        .cx(hx), .cy(hy), .fg(fg), .blk(blk),
        .cand_ok(cand_ok), .nx(nx), .ny(ny), .na(na)
    );

    always_comb begin
        for (int s = 0; s < NSLOT; s++)
            new_mask[s] = cand_ok[s] & fg[na[s]] & ~vis[na[s]];
    end

    // lowest pending candidate
    logic [SW-1:0] pick_s;
    logic          pick_hit;
    always_comb begin
        pick_s   = '0;
        pick_hit = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            if (!pick_hit && cand_q[s]) begin
                pick_hit = 1'b1;
                pick_s   = SW'(s);
            end
        end
    end

    logic seed_hit, cnt_last;
    assign seed_hit = fg[cnt] & ~vis[cnt];
    assign cnt_last = (cnt == AW'(NPT - 1));

    // frontier control
    assign f_clear = (state == ST_IDLE);
    assign f_push  = (state == ST_SCAN && seed_hit) || (state == ST_PUSH && pick_hit);
    assign f_pop   = (state == ST_POP) && !f_empty;
    assign f_wdata = (state == ST_SCAN) ? {2'b00, 1'b0, cy, cx}
                                        : {2'b00, mode_q, cand_y_q[pick_s], cand_x_q[pick_s]};

    rg_frontier_fifo #(.DEPTH(NPT), .WW(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(f_clear), .push(f_push), .wdata(f_wdata),
        .pop(f_pop), .rdata(f_rdata), .empty(f_empty), .full(f_full)
    );

    // bounding box
    logic          bb_upd;
    logic [CW-1:0] bb_ux, bb_uy, bb_min_x, bb_max_x, bb_min_y, bb_max_y;
    assign bb_upd = (state == ST_PUSH && pick_hit) || (f_pop && blk);
    assign bb_ux  = (state == ST_PUSH) ? cand_x_q[pick_s] : hx + CW'(1);
    assign bb_uy  = (state == ST_PUSH) ? cand_y_q[pick_s] : hy + CW'(1);

    rg_bbox #(.CW(CW)) u_bbox (
        .clk(clk), .rst_n(rst_n), .init(state == ST_SCAN && seed_hit), .ix(cx), .iy(cy),
        .upd(bb_upd), .ux(bb_ux), .uy(bb_uy),
        .min_x(bb_min_x), .max_x(bb_max_x), .min_y(bb_min_y), .max_y(bb_max_y)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   if (start) nstate = ST_LOAD;
            ST_LOAD:   if (cnt_last) nstate = ST_SCAN;
            ST_SCAN:   if (seed_hit) nstate = ST_POP;
                       else if (cnt_last) nstate = ST_FINISH;
            ST_POP:    if (f_empty) nstate = ST_EMIT;
                       else if (new_mask != '0) nstate = ST_PUSH;
            ST_PUSH:   if ((cand_q & ~(NSLOT'(1) << pick_s)) == '0) nstate = ST_POP;
            ST_EMIT:   nstate = ST_SCAN;
            ST_FINISH: nstate = ST_IDLE;
            default:   nstate = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fg       <= '0;
            vis      <= '0;
            cnt      <= '0;
            cx       <= '0;
            cy       <= '0;
            ox_q     <= '0;
            oy_q     <= '0;
            cand_q   <= '0;
            cand_x_q <= '0;
            cand_y_q <= '0;
            mode_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    cnt  <= '0;
                    cx   <= '0;
                    cy   <= '0;
                    vis  <= '0;
                    ox_q <= org_x;
                    oy_q <= org_y;
                end
                ST_LOAD, ST_SCAN: begin
                    if (state == ST_LOAD) fg[cnt] <= tile_rd_data;
                    if (state == ST_SCAN && seed_hit) begin
                        vis[cnt] <= 1'b1;
                    end else if (cnt_last) begin
                        cnt <= '0;
                        cx  <= '0;
                        cy  <= '0;
                    end else begin
                        cnt <= cnt + AW'(1);
                        if (cx == CW'(TILE_W - 1)) begin
                            cx <= '0;
                            cy <= cy + CW'(1);
                        end else begin
                            cx <= cx + CW'(1);
                        end
                    end
                end
                ST_POP: if (!f_empty) begin
                    for (int s = 0; s < NSLOT; s++)
                        if (new_mask[s]) vis[na[s]] <= 1'b1;
                    if (blk) begin
                        vis[head_a + AW'(1)]          <= 1'b1;
                        vis[head_a + AW'(TILE_W)]     <= 1'b1;
                        vis[head_a + AW'(TILE_W + 1)] <= 1'b1;
                    end
                    cand_q   <= new_mask;
                    cand_x_q <= nx;
                    cand_y_q <= ny;
                    mode_q   <= blk;
                end
                ST_PUSH: cand_q <= cand_q & ~(NSLOT'(1) << pick_s);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        tile_rd_addr = (state == ST_LOAD) ? cnt : '0;
        region_valid = (state == ST_EMIT);
        done         = (state == ST_FINISH);
        region_min_x = ox_q + ORG_W'(bb_min_x);
        region_max_x = ox_q + ORG_W'(bb_max_x);
        region_min_y = oy_q + ORG_W'(bb_min_y);
        region_max_y = oy_q + ORG_W'(bb_max_y);
    end

    // assertions
    p_load_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && $past(state) == ST_LOAD) |-> tile_rd_addr == $past(tile_rd_addr) + AW'(1));
    p_box_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        region_valid |-> (region_min_x <= region_max_x) && (region_min_y <= region_max_y));
    p_emit_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        region_valid |-> f_empty);
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && region_valid));
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> $stable(ox_q) && $stable(oy_q));
    p_word_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !f_empty |-> f_rdata[WORD_W-1:2*CW+1] == '0);

endmodule

// File: tb/tile_region_grower_bench.sv
`timescale 1ns/1ps
module tile_region_grower_bench;

    localparam int TW = 20;
    localparam int TH = 20;
    localparam int NPT = TW * TH;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] org_x = '0, org_y = '0;
    logic [8:0] tile_rd_addr;
    logic       tile_rd_data;
    logic       region_valid, done;
    logic [6:0] region_min_x, region_max_x, region_min_y, region_max_y;

    logic [NPT-1:0] tile_img = '0;

    always #10 clk = ~clk;

    assign tile_rd_data = (tile_rd_addr < 9'(NPT)) ? tile_img[tile_rd_addr] : 1'b0;

    tile_region_grower u_tile_region_grower (
        .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
        .tile_rd_addr(tile_rd_addr), .tile_rd_data(tile_rd_data),
        .region_valid(region_valid), .region_min_x(region_min_x), .region_max_x(region_max_x),
        .region_min_y(region_min_y), .region_max_y(region_max_y), .done(done)
    );

    int n_checks = 0;
    int n_fails  = 0;

    int e_minx [NPT], e_maxx [NPT], e_miny [NPT], e_maxy [NPT];
    int g_minx [NPT], g_maxx [NPT], g_miny [NPT], g_maxy [NPT];
    int n_exp, n_got;
    int qbuf [NPT];
    bit lab [NPT];

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // 4-connected flood fill, regions ordered by lowest raster address
    task automatic compute_expected(input int ox, input int oy);
        int head, tail, c, x, y, nxx, nyy;
        int mnx, mxx, mny, mxy;
        n_exp = 0;
        for (int a = 0; a < NPT; a++) lab[a] = 1'b0;
        for (int a = 0; a < NPT; a++) begin
            if (tile_img[a] && !lab[a]) begin
                head = 0; tail = 0;
                qbuf[tail++] = a; lab[a] = 1'b1;
                mnx = a % TW; mxx = mnx; mny = a / TW; mxy = mny;
                while (head < tail) begin
                    c = qbuf[head++];
                    x = c % TW; y = c / TW;
                    if (x < mnx) mnx = x;
                    if (x > mxx) mxx = x;
                    if (y < mny) mny = y;
                    if (y > mxy) mxy = y;
                    for (int d = 0; d < 4; d++) begin
                        nxx = x + ((d == 0) ? -1 : (d == 1) ? 1 : 0);
                        nyy = y + ((d == 2) ? -1 : (d == 3) ? 1 : 0);
                        if (nxx >= 0 && nxx < TW && nyy >= 0 && nyy < TH) begin
                            if (tile_img[nyy*TW+nxx] && !lab[nyy*TW+nxx]) begin
                                lab[nyy*TW+nxx] = 1'b1;
                                qbuf[tail++] = nyy*TW+nxx;
                            end
                        end
                    end
                end
                e_minx[n_exp] = mnx + ox; e_maxx[n_exp] = mxx + ox;
                e_miny[n_exp] = mny + oy; e_maxy[n_exp] = mxy + oy;
                n_exp++;
            end
        end
    endtask

    task automatic run_tile(input int ox, input int oy, input bit disturb, input string req);
        int k, addr_err;
        bit fin;
        compute_expected(ox, oy);
        @(negedge clk);
        org_x = 7'(ox); org_y = 7'(oy); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0; addr_err = 0; fin = 1'b0; n_got = 0;
        while (!fin && k < 20000) begin
            if (k < NPT && int'(tile_rd_addr) != k) addr_err++;
            if (region_valid) begin
                if (done) check(1'b0, "R6", "done with region_valid", 1, 0);
                if (n_got < NPT) begin
                    g_minx[n_got] = int'(region_min_x); g_maxx[n_got] = int'(region_max_x);
                    g_miny[n_got] = int'(region_min_y); g_maxy[n_got] = int'(region_max_y);
                end
                n_got++;
            end
            if (done) fin = 1'b1;
            else if (disturb && (k == 50 || k == 420)) begin
                start = 1'b1; org_x = 7'(ox + 3); org_y = 7'(oy + 5);
            end else begin
                start = 1'b0; org_x = 7'(ox); org_y = 7'(oy);
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        check(fin, req, "done reached (R6)", int'(fin), 1);
        check(addr_err == 0, "R2", "load address sequence errors", addr_err, 0);
        check(n_got == n_exp, req, "region count (R3)", n_got, n_exp);
        check(done == 1'b0, "R6", "done one cycle wide", int'(done), 0);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            check(g_minx[i] == e_minx[i] && g_maxx[i] == e_maxx[i] &&
                  g_miny[i] == e_miny[i] && g_maxy[i] == e_maxy[i], req,
                  $sformatf("region %0d box (R3 R4 R5) minx/maxx/miny/maxy %0d/%0d/%0d/%0d vs %0d/%0d/%0d/%0d",
                            i, g_minx[i], g_maxx[i], g_miny[i], g_maxy[i],
                            e_minx[i], e_maxx[i], e_miny[i], e_maxy[i]),
                  g_minx[i], e_minx[i]);
        end
        repeat (3) @(negedge clk);
        check(done == 1'b0 && region_valid == 1'b0, req, "quiet after done (R7)", int'(done), 0);
    endtask

    task automatic fill_random(input int pct);
        for (int a = 0; a < NPT; a++) tile_img[a] = (($urandom % 100) < pct);
    endtask

    task automatic set_px(input int x, input int y);
        tile_img[y*TW+x] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(region_valid == 1'b0 && done == 1'b0, "R1", "outputs low in reset", int'(region_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(region_valid == 1'b0 && done == 1'b0, "R1", "outputs low after reset", int'(done), 0);
        check(tile_rd_addr == '0, "R1", "read address after reset", int'(tile_rd_addr), 0);

        // R6: empty tile, only done
        tile_img = '0;
        run_tile(0, 0, 1'b0, "R6");

        // R8 R10: full tile is one region, deepest frontier use
        tile_img = '1;
        run_tile(20, 40, 1'b0, "R8");

        // R9: first and last address, diagonal pair
        tile_img = '0;
        set_px(0, 0); set_px(19, 19); set_px(5, 5); set_px(6, 6); set_px(19, 0); set_px(0, 1);
        run_tile(60, 20, 1'b0, "R9");

        // R9: checkerboard, every cell isolated
        for (int a = 0; a < NPT; a++) tile_img[a] = (((a % TW) + (a / TW)) % 2 == 0);
        run_tile(40, 0, 1'b0, "R9");

        // R8: concave U of blocks plus blocks on right and bottom edges
        tile_img = '0;
        for (int y = 2; y < 12; y++) begin set_px(2, y); set_px(3, y); set_px(10, y); set_px(11, y); end
        for (int x = 2; x < 12; x++) begin set_px(x, 10); set_px(x, 11); end
        for (int y = 0; y < 20; y++) begin set_px(18, y); set_px(19, y); end
        for (int x = 0; x < 16; x++) begin set_px(x, 18); set_px(x, 19); end
        set_px(14, 14); set_px(15, 14); set_px(15, 15); set_px(16, 15); set_px(16, 16);
        run_tile(0, 40, 1'b0, "R8");

        // R3 R4 R5: random fills at several densities and origins
        for (int t = 0; t < 6; t++) begin
            fill_random((t == 0) ? 10 : (t == 1) ? 30 : (t == 2) ? 45 : (t == 3) ? 55 : (t == 4) ? 65 : 80);
            run_tile(20 * int'($urandom % 4), 20 * int'($urandom % 3), 1'b0, "R3");
        end

        // R7: extra start pulses during load and scan
        fill_random(40);
        run_tile(20, 20, 1'b1, "R7");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule